// File: doc/BRIEF.md
# Countdown Timer Channel Bank

This block holds a set of independent down-counting timer channels. Each channel has a control register, an initial-count register and a read-only live count. The live count drops by one on every prescaled tick of the block clock. A channel stops by itself when it reaches zero in one-shot mode, or reloads and keeps running in periodic mode. Software can restart a channel from its initial count, pause it and resume it from the held value.

Every expiry sets the channel's bit in one shared status register. Software clears that bit by writing 1 to it. Each channel has its own interrupt line, which is high exactly while the channel's interrupt enable and its status bit are both set. Access goes through a single-cycle register port. A write takes effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

The address is a word index `{channel, sel}`, with the two low bits as `sel`. For a channel, `sel`=0 is control, 1 is initial count, 2 is live count and 3 reads 0. Channel index NUM_CH selects the status register. Any other index reads 0.

Top module: `tmr_bank`

## Requirements
- R1: After reset every control register reads 0x00000005, every initial-count and live-count register reads 0, the status register reads 0 and all interrupt outputs are low.
- R2: The control register layout is: enable at bit 30, interrupt enable at bit 29, periodic mode at bit 27, restart request at bit 26, read-only active flag at bit 25 (equal to enable), prescaler at bits 7:0. Bits 31, 28 and 24:8 ignore writes and read 0, and so does a write to bit 25.
- R3: While enabled, the live count decrements once every (prescaler+1) clocks. The first decrement falls on the (prescaler+1)-th rising edge after the edge of the enabling write.
- R4: A tick that finds the live count at 1 or 0 is an expiry, and it sets the channel's bit i of the status register on that edge.
- R5: In one-shot mode (bit 27 = 0) an expiry leaves the live count at 0 and clears the enable and active flags.
- R6: In periodic mode (bit 27 = 1) an expiry loads the initial count on the same edge, and the channel keeps running.
- R7: Interrupt output i is high exactly while the interrupt-enable bit of channel i and status bit i are both 1.
- R8: Writing 1 to status bit i clears it, and writing 0 leaves it unchanged. An expiry on the same edge as a clear leaves the bit set.
- R9: Writing a control word with bit 26 set loads the live count from the initial-count register. Bit 26 always reads back 0.
- R10: Clearing enable freezes the live count and clears the active flag, and setting enable again resumes counting from the held value. If the channel was enabled and the count is 0 after any restart in the same write, that write counts as an expiry: the status bit is set, and in periodic mode the initial count is loaded.
- R11: A control write that changes only the prescaler leaves the live count unchanged. Every control write restarts the prescaler phase.
- R12: Writes to the live-count register are ignored. Writing the initial-count register does not change the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the count reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_addr | input | ADDR_W | Word address {channel, sel} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
The bench builds the block with its defaults: five channels, a 24-bit live count and an 8-bit prescaler. These values make the status register sit at channel index 5, so an out-of-range index and the status decode both fall inside the 5-bit address. A prescaler of 0 gives a tick on every clock, which makes one-shot stops, periodic reloads and expiry-versus-clear collisions happen within a few cycles. Large prescalers show that a restart or an initial-count write lands before any tick. The behavioural model checks every read address and every interrupt line on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int BIT_EN   = 30;
   localparam int BIT_IE   = 29;
   localparam int BIT_PER  = 27;
   localparam int BIT_RST  = 26;
   localparam int BIT_ACT  = 25;
   localparam int MAX_PRE_W = 8;
   localparam int RST_PRE  = 5;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_INIT = 2'd1,
      SEL_CNT  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   logic [PRE_W-1:0] phase_q;

   assign tick = run && !clr && (phase_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               phase_q <= '0;
      else if (!run || clr)     phase_q <= '0;
      else if (phase_q == limit) phase_q <= '0;
      else                      phase_q <= phase_q + 1'b1;
   end

   // phase never passes the limit: the limit only moves together with clr
   assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= limit);
   assert_idle_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> phase_q == '0);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 24,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_init,
   input  logic             c_en,
   input  logic             c_ie,
   input  logic             c_per,
   input  logic             c_rst,
   input  logic [PRE_W-1:0] c_pre,
   input  logic [CNT_W-1:0] init_wd,
   output logic [31:0]      ctrl_rd,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] init_q,
   output logic             ie_q,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             en_q, per_q, tick;
   logic [PRE_W-1:0] pre_q;
   logic             en_d, ie_d, per_d;
   logic [PRE_W-1:0] pre_d;
   logic [CNT_W-1:0] cnt_d, reload;

   tmr_prescale #(.PRE_W(PRE_W)) i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en_q),
      .clr   (wr_ctrl),
      .limit (pre_q),
      .tick  (tick)
   );

   always_comb begin
      en_d   = en_q;
      ie_d   = ie_q;
      per_d  = per_q;
      pre_d  = pre_q;
      cnt_d  = cnt_q;
      expire = 1'b0;
      reload = c_rst ? init_q : cnt_q;
      if (wr_ctrl) begin
         ie_d  = c_ie;
         per_d = c_per;
         pre_d = c_pre;
         en_d  = c_en;
         if (!c_en && en_q && reload == '0) begin
            expire = 1'b1;
            cnt_d  = c_per ? init_q : '0;
         end else begin
            cnt_d = reload;
         end
      end else if (tick) begin
         if (cnt_q <= ONE) begin
            expire = 1'b1;
            if (per_q) cnt_d = init_q;
            else begin
               cnt_d = '0;
               en_d  = 1'b0;
            end
         end else begin
            cnt_d = cnt_q - ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         ie_q   <= 1'b0;
         per_q  <= 1'b0;
         pre_q  <= PRE_W'(RST_PRE);
         cnt_q  <= '0;
         init_q <= '0;
      end else begin
         en_q  <= en_d;
         ie_q  <= ie_d;
         per_q <= per_d;
         pre_q <= pre_d;
         cnt_q <= cnt_d;
         if (wr_init) init_q <= init_wd;
      end
   end

   always_comb begin
      ctrl_rd          = '0;
      ctrl_rd[BIT_EN]  = en_q;
      ctrl_rd[BIT_IE]  = ie_q;
      ctrl_rd[BIT_PER] = per_q;
      ctrl_rd[BIT_ACT] = en_q;
      ctrl_rd[PRE_W-1:0] = pre_q;
   end

   assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_ctrl && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);
   assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_ctrl && !per_q && cnt_q <= ONE) |=> (!en_q && cnt_q == '0));
   assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_ctrl && per_q && cnt_q <= ONE) |=> (en_q && cnt_q == $past(init_q)));
   assert_restart_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && c_rst && c_en) |=> cnt_q == $past(init_q));
   assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !wr_ctrl) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 5,
   parameter int CNT_W  = 24,
   parameter int PRE_W  = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int CH_W = ADDR_W - 2;
   localparam logic [CH_W-1:0] STS_IDX = CH_W'(NUM_CH);

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= 31) else $fatal(1, "NUM_CH out of range");
      assert (CNT_W >= 2 && CNT_W <= 32) else $fatal(1, "CNT_W out of range");
      assert (PRE_W >= 3 && PRE_W <= MAX_PRE_W) else $fatal(1, "PRE_W out of range");
      assert (CH_W >= $clog2(NUM_CH + 1)) else $fatal(1, "ADDR_W too small");
   end

   logic [CH_W-1:0]   ch_idx;
   reg_sel_e          sel;
   logic              sts_wr;
   logic [NUM_CH-1:0] sts_q, sts_d, exp_v, ie_v;
   logic [31:0]       ctrl_rd [NUM_CH];
   logic [CNT_W-1:0]  cnt_v   [NUM_CH];
   logic [CNT_W-1:0]  init_v  [NUM_CH];
   logic              unused_wdata;

   assign ch_idx       = bus_addr[ADDR_W-1:2];
   assign sel          = reg_sel_e'(bus_addr[1:0]);
   assign sts_wr       = bus_wr && (ch_idx == STS_IDX);
   assign unused_wdata = ^bus_wdata;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = bus_wr && (ch_idx == CH_W'(i));

      tmr_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_ctrl (hit && sel == SEL_CTRL),
         .wr_init (hit && sel == SEL_INIT),
         .c_en    (bus_wdata[BIT_EN]),
         .c_ie    (bus_wdata[BIT_IE]),
         .c_per   (bus_wdata[BIT_PER]),
         .c_rst   (bus_wdata[BIT_RST]),
         .c_pre   (bus_wdata[PRE_W-1:0]),
         .init_wd (bus_wdata[CNT_W-1:0]),
         .ctrl_rd (ctrl_rd[i]),
         .cnt_q   (cnt_v[i]),
         .init_q  (init_v[i]),
         .ie_q    (ie_v[i]),
         .expire  (exp_v[i])
      );

      assert_status_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
         exp_v[i] |=> sts_q[i]);
      assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_wr && bus_wdata[i] && !exp_v[i]) |=> !sts_q[i]);
      assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_q[i] && !sts_wr) |=> sts_q[i]);
   end

   always_comb begin
      sts_d = sts_q;
      if (sts_wr) sts_d = sts_d & ~bus_wdata[NUM_CH-1:0];
      sts_d = sts_d | exp_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= sts_d;
   end

   assign irq = sts_q & ie_v;

   always_comb begin
      bus_rdata = '0;
      if (ch_idx == STS_IDX) begin
         bus_rdata[NUM_CH-1:0] = sts_q;
      end else begin
         for (int k = 0; k < NUM_CH; k++) begin
            if (ch_idx == CH_W'(k)) begin
               case (sel)
                  SEL_CTRL: bus_rdata = ctrl_rd[k];
                  SEL_INIT: bus_rdata[CNT_W-1:0] = init_v[k];
                  SEL_CNT:  bus_rdata[CNT_W-1:0] = cnt_v[k];
                  default:  bus_rdata = '0;
               endcase
            end
         end
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (sts_q == '0));
endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
   localparam int NCH = 5;
   localparam int STS = NCH * 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  irq;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   // behavioural model state
   int m_en[NCH], m_ie[NCH], m_per[NCH], m_pre[NCH], m_pc[NCH];
   int m_init[NCH], m_cnt[NCH];
   int m_sts;

   always #2 clk = ~clk;

   tmr_bank i_tmr_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic m_reset();
      for (int i = 0; i < NCH; i++) begin
         m_en[i] = 0; m_ie[i] = 0; m_per[i] = 0; m_pre[i] = 5;
         m_pc[i] = 0; m_init[i] = 0; m_cnt[i] = 0;
      end
      m_sts = 0;
   endtask

   initial m_reset();

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else begin
         int ch, sel, ex, ca;
         int clr_mask;
         ch = int'(bus_addr) >> 2;
         sel = int'(bus_addr) & 3;
         clr_mask = (bus_wr && ch == NCH) ? int'(bus_wdata[NCH-1:0]) : 0;
         m_sts = m_sts & ~clr_mask;
         for (int i = 0; i < NCH; i++) begin
            bit wc, tk;
            wc = bus_wr && ch == i && sel == 0;
            tk = m_en[i] != 0 && !wc && m_pc[i] == m_pre[i];
            ex = 0;
            if (m_en[i] == 0 || wc || m_pc[i] == m_pre[i]) m_pc[i] = 0;
            else m_pc[i] = m_pc[i] + 1;
            if (wc) begin
               ca = bus_wdata[26] ? m_init[i] : m_cnt[i];
               m_ie[i] = bus_wdata[29]; m_per[i] = bus_wdata[27];
               m_pre[i] = int'(bus_wdata[7:0]);
               if (bus_wdata[30]) begin m_cnt[i] = ca; m_en[i] = 1; end
               else begin
                  if (m_en[i] != 0 && ca == 0) begin
                     ex = 1; m_cnt[i] = bus_wdata[27] ? m_init[i] : 0;
                  end else m_cnt[i] = ca;
                  m_en[i] = 0;
               end
            end else if (tk) begin
               if (m_cnt[i] <= 1) begin
                  ex = 1;
                  if (m_per[i] != 0) m_cnt[i] = m_init[i];
                  else begin m_cnt[i] = 0; m_en[i] = 0; end
               end else m_cnt[i] = m_cnt[i] - 1;
            end
            if (bus_wr && ch == i && sel == 1) m_init[i] = int'(bus_wdata[23:0]);
            if (ex != 0) m_sts = m_sts | (1 << i);
         end
      end
   end

   function automatic int m_read(int a);
      int ch, sel;
      ch = a >> 2; sel = a & 3;
      if (ch == NCH) return m_sts;
      if (ch > NCH) return 0;
      case (sel)
         0: return (m_en[ch] << 30) | (m_ie[ch] << 29) | (m_per[ch] << 27)
                   | (m_en[ch] << 25) | m_pre[ch];
         1: return m_init[ch];
         2: return m_cnt[ch];
         default: return 0;
      endcase
   endfunction

   function automatic int m_irq();
      int v = 0;
      for (int i = 0; i < NCH; i++) if (m_ie[i] != 0 && m_sts[i]) v |= (1 << i);
      return v;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always begin
      @(negedge clk); #1;
      if (rst_n && !done) begin
         string tag;
         case (int'(bus_addr) & 3)
            0: tag = "R2 ctrl read";
            1: tag = "R12 init read";
            2: tag = "R3 count read";
            default: tag = "R2 spare read";
         endcase
         if ((int'(bus_addr) >> 2) == NCH) tag = "R8 status read";
         chk(tag, bus_rdata, 32'(m_read(int'(bus_addr))));
         chk("R7 irq lines", 32'(irq), 32'(m_irq()));
      end
   end

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(int a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = 5'(a);
      #1 v = bus_rdata;
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         finish_run();
      end
   end

   initial begin
      logic [31:0] v, v1, v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      rd(0, v);  chk("R1 ctrl reset", v, 32'h0000_0005);
      rd(1, v);  chk("R1 init reset", v, 32'h0);
      rd(2, v);  chk("R1 count reset", v, 32'h0);
      rd(STS, v); chk("R1 status reset", v, 32'h0);
      chk("R1 irq reset", 32'(irq), 32'h0);

      // channel 0 one-shot, prescaler 0, restart
      wr(1, 32'd3);
      wr(0, 32'h4400_0000);
      rd(0, v);  chk("R9 restart reads 0 / R2 active", v, 32'h4200_0000);
      repeat (6) @(negedge clk);
      rd(0, v);  chk("R5 one-shot stops", v, 32'h0);
      rd(2, v);  chk("R5 count at zero", v, 32'h0);
      rd(STS, v); chk("R4 status bit 0", v, 32'h1);
      chk("R7 irq masked", 32'(irq), 32'h0);
      wr(0, 32'h2000_0000);
      chk("R7 irq raised", 32'(irq), 32'h1);
      wr(STS, 32'h0);
      rd(STS, v); chk("R8 write 0 keeps", v, 32'h1);
      wr(STS, 32'h1);
      rd(STS, v); chk("R8 write 1 clears", v, 32'h0);
      chk("R7 irq dropped", 32'(irq), 32'h0);

      // channel 1 periodic
      wr(5, 32'd4);
      wr(4, 32'h6C00_0001);
      repeat (40) @(negedge clk);
      rd(4, v);  chk("R6 periodic keeps running", v, 32'h6A00_0001);
      rd(STS, v); chk("R4 status bit 1", v & 32'h2, 32'h2);
      chk("R7 irq 1", 32'(irq) & 32'h2, 32'h2);
      wr(4, 32'h0);
      wr(STS, 32'h2);

      // channel 2 pause / resume, prescaler change
      wr(9, 32'd100);
      wr(8, 32'h4400_0000);
      repeat (10) @(negedge clk);
      wr(8, 32'h0);
      rd(10, v1);
      repeat (10) @(negedge clk);
      rd(10, v2); chk("R10 frozen count", v2, v1);
      rd(8, v);   chk("R10 active cleared", v, 32'h0);
      wr(8, 32'h0000_00FF);
      rd(10, v);  chk("R11 prescaler change keeps count", v, v1);
      wr(8, 32'h4000_0000);
      repeat (5) @(negedge clk);
      rd(10, v);  chk("R10 resumed from held value", 32'(v < v1), 32'h1);
      wr(8, 32'h0);

      // channel 3: init write while running, disable at zero
      wr(13, 32'd50);
      wr(12, 32'h4400_00C8);
      wr(13, 32'd0);
      rd(14, v);  chk("R12 init write keeps count", v, 32'd50);
      wr(12, 32'h0400_0000);
      rd(14, v);  chk("R10 restart to zero on disable", v, 32'h0);
      rd(STS, v); chk("R10 disable at zero expires", v, 32'h8);
      wr(STS, 32'h8);

      // channel 4: reserved bits, read-only count, prescaled run
      wr(16, 32'h93FF_FF03);
      rd(16, v);  chk("R2 reserved and active ignored", v, 32'h3);
      wr(18, 32'h55);
      rd(18, v);  chk("R12 count write ignored", v, 32'h0);
      wr(17, 32'd10);
      wr(16, 32'h4400_0002);
      repeat (40) @(negedge clk);
      rd(18, v);  chk("R3 prescaled countdown done", v, 32'h0);
      rd(STS, v); chk("R3 expiry after ten ticks", v, 32'h10);
      rd(16, v);  chk("R5 one-shot ctrl", v, 32'h2);

      // collision of expiry and clear on channel 0 (periodic, every tick)
      wr(1, 32'd1);
      wr(0, 32'h4C00_0000);
      repeat (4) @(negedge clk);
      wr(STS, 32'h1);
      rd(STS, v); chk("R8 set wins over clear", v & 32'h1, 32'h1);
      wr(0, 32'h0);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule